// File: doc/BRIEF.md
# LCD Power Sequencer

This block brings an LCD panel and its backlight up and down in a fixed, mirrored order. A wake request turns on the panel supply, then the backlight supply, then raises the luminance code to full scale. A sleep request, or a standby request, which is handled the same way, first drops luminance to zero, then removes the backlight supply, then removes the panel supply. A programmable wait separates consecutive steps so that the external supplies can settle.

Requests are single-cycle pulses. They pass through a one-entry pending slot. A request that arrives while a sequence is running waits in the slot until the sequence finishes, and a newer request overwrites an older one that has not yet been served. A wake request is refused when the display does not own the console. Straight after reset the slot holds a boot request. This request resolves to a wake when the console flag is high when the request is served, and to a sleep when it is low. A `busy` level covers each running sequence, and a one-cycle `done` pulse marks its end.

Top module: `lcd_pwr_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `lcd_pwr_en` and `bl_pwr_en` are low, `lum_level` is 0x00, and `busy` and `done` are low.
- R2: The first operation after reset is a boot request. It resolves to the wake order when `console_own` is high at the first clock edge after reset, and otherwise to the sleep order. The sleep order keeps every output off, but `busy` and `done` still behave as for any sequence.
- R3: Wake order: `lcd_pwr_en` rises on the first step. `bl_pwr_en` rises STEP_WAIT cycles later. `lum_level` becomes all ones (0xFF) STEP_WAIT cycles after that. The backlight is never on while the panel supply is off.
- R4: Sleep order: `lum_level` drops to 0x00 on the first step. `bl_pwr_en` falls STEP_WAIT cycles later. `lcd_pwr_en` falls STEP_WAIT cycles after that. A non-zero luminance never appears while the backlight is off.
- R5: A `standby_req` pulse produces exactly the same output sequence and timing as a `suspend_req` pulse.
- R6: A wake request served while `console_own` is low changes no output. It leaves `busy` low and raises `done` for one cycle on the cycle after it is served.
- R7: `busy` is high from the cycle after the first step to the cycle of the last step, which is 2·STEP_WAIT cycles. `done` is high for the single cycle after the last step. `busy` and `done` are never high together, and the outputs change only on a cycle in which `busy` or `done` is high.
- R8: A request that arrives while `busy` is high is held and served on the clock edge after `done`. If several requests arrive before that edge, only the newest is served.
- R9: When a wake pulse and a sleep or standby pulse arrive in the same cycle, the sleep order is the one recorded.
- R10: A request sampled at a clock edge while the block is idle with nothing pending takes its first step at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resume_req | input | 1 | Wake request pulse |
| suspend_req | input | 1 | Sleep request pulse |
| standby_req | input | 1 | Standby request pulse, treated as sleep |
| console_own | input | 1 | High when the display owns the console |
| lcd_pwr_en | output | 1 | Panel supply enable |
| bl_pwr_en | output | 1 | Backlight supply enable |
| lum_level | output | LUM_W | Luminance code, all zeros or all ones |
| busy | output | 1 | A power sequence is running |
| done | output | 1 | One-cycle pulse at the end of each served request |

## Verification
The bench builds the block with STEP_WAIT set to 3 and keeps the default 8-bit luminance. The short step wait keeps a whole sequence to six cycles. That makes it practical to land requests at chosen points inside a running sequence: overwriting a pending request, a request arriving in the `done` cycle, and same-cycle conflicts. A behavioural model driven by elapsed cycle counts checks every clock. Directed checks pin the step spacing and the first-step latency.

// File: rtl/lcdpwr_pkg.sv
package lcdpwr_pkg;

    // Kind of request held in the pending slot
    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_WAKE  = 2'd1,
        REQ_SLEEP = 2'd2,
        REQ_BOOT  = 2'd3
    } req_kind_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Power rails as seen by the panel
    typedef struct packed {
        logic lcd;
        logic bl;
        logic lum_hi;
    } rail_t;

    localparam logic [1:0] STEP_FIRST = 2'd0;
    localparam logic [1:0] STEP_LAST  = 2'd2;

    // Sleep and standby dominate a simultaneous wake
    function automatic req_kind_e pick_request(input logic wake,
                                               input logic sleep,
                                               input logic stby);
        if (sleep || stby)
            return REQ_SLEEP;
        else if (wake)
            return REQ_WAKE;
        else
            return REQ_NONE;
    endfunction

    // Effect of one step: the up order is panel, backlight, luminance;
    // the down order mirrors it
    function automatic rail_t apply_step(input rail_t cur,
                                         input logic up,
                                         input logic [1:0] step);
        rail_t nxt;
        nxt = cur;
        if (up) begin
            case (step)
                2'd0:    nxt.lcd    = 1'b1;
                2'd1:    nxt.bl     = 1'b1;
                default: nxt.lum_hi = 1'b1;
            endcase
        end else begin
            case (step)
                2'd0:    nxt.lum_hi = 1'b0;
                2'd1:    nxt.bl     = 1'b0;
                default: nxt.lcd    = 1'b0;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/lcdpwr_req_latch.sv
module lcdpwr_req_latch
    import lcdpwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wake_i,
    input  logic      sleep_i,
    input  logic      stby_i,
    input  logic      take_i,
    output logic      pend_valid_o,
    output req_kind_e pend_kind_o
);

    req_kind_e incoming;
    req_kind_e slot_q;

    assign incoming = pick_request(wake_i, sleep_i, stby_i);

    // A fresh request overwrites the slot, even in the cycle it is taken
    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= REQ_BOOT;
        else if (incoming != REQ_NONE)
            slot_q <= incoming;
        else if (take_i)
            slot_q <= REQ_NONE;
    end

    assign pend_valid_o = (slot_q != REQ_NONE);
    assign pend_kind_o  = slot_q;

endmodule

// File: rtl/lcdpwr_step_timer.sv
module lcdpwr_step_timer #(
    parameter int STEP_WAIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);

    localparam int CNT_W = (STEP_WAIT > 1) ? $clog2(STEP_WAIT) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STEP_WAIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcdpwr_seq_fsm.sv
module lcdpwr_seq_fsm
    import lcdpwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pend_valid_i,
    input  req_kind_e pend_kind_i,
    input  logic      console_own_i,
    input  logic      expired_i,
    output logic      take_o,
    output logic      timer_load_o,
    output rail_t     rails_o,
    output logic      busy_o,
    output logic      done_o
);

    seq_state_e state_q;
    logic [1:0] step_q;
    logic       up_q;
    rail_t      rails_q;
    logic       done_q;

    logic go_up;
    logic refuse;
    logic last_fire;

    assign take_o = (state_q == SEQ_IDLE) && pend_valid_i;

    // Resolve the pending kind against the console flag at take time
    assign go_up  = ((pend_kind_i == REQ_WAKE) || (pend_kind_i == REQ_BOOT)) && console_own_i;
    assign refuse = (pend_kind_i == REQ_WAKE) && !console_own_i;

    assign last_fire    = (state_q == SEQ_RUN) && expired_i && (step_q == STEP_LAST);
    assign timer_load_o = (take_o && !refuse) ||
                          ((state_q == SEQ_RUN) && expired_i && !last_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            step_q  <= STEP_FIRST;
            up_q    <= 1'b0;
            rails_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (take_o) begin
                        if (refuse) begin
                            done_q <= 1'b1;
                        end else begin
                            rails_q <= apply_step(rails_q, go_up, STEP_FIRST);
                            up_q    <= go_up;
                            step_q  <= STEP_FIRST + 2'd1;
                            state_q <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (expired_i) begin
                        rails_q <= apply_step(rails_q, up_q, step_q);
                        if (step_q == STEP_LAST) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            step_q <= step_q + 2'd1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign rails_o = rails_q;
    assign busy_o  = (state_q == SEQ_RUN);
    assign done_o  = done_q;

endmodule

// File: rtl/lcd_pwr_sequencer.sv
module lcd_pwr_sequencer
    import lcdpwr_pkg::*;
#(
    parameter int STEP_WAIT = 4,
    parameter int LUM_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             resume_req,
    input  logic             suspend_req,
    input  logic             standby_req,
    input  logic             console_own,
    output logic             lcd_pwr_en,
    output logic             bl_pwr_en,
    output logic [LUM_W-1:0] lum_level,
    output logic             busy,
    output logic             done
);

    localparam logic [LUM_W-1:0] LUM_MIN = '0;
    localparam logic [LUM_W-1:0] LUM_MAX = '1;

    logic      pend_valid;
    req_kind_e pend_kind;
    logic      take;
    logic      timer_load;
    logic      expired;
    rail_t     rails;

    lcdpwr_req_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .wake_i       (resume_req),
        .sleep_i      (suspend_req),
        .stby_i       (standby_req),
        .take_i       (take),
        .pend_valid_o (pend_valid),
        .pend_kind_o  (pend_kind)
    );

    lcdpwr_step_timer #(.STEP_WAIT(STEP_WAIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (timer_load),
        .expired_o (expired)
    );

    lcdpwr_seq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .pend_valid_i  (pend_valid),
        .pend_kind_i   (pend_kind),
        .console_own_i (console_own),
        .expired_i     (expired),
        .take_o        (take),
        .timer_load_o  (timer_load),
        .rails_o       (rails),
        .busy_o        (busy),
        .done_o        (done)
    );

    assign lcd_pwr_en = rails.lcd;
    assign bl_pwr_en  = rails.bl;
    assign lum_level  = rails.lum_hi ? LUM_MAX : LUM_MIN;

endmodule

// File: rtl/lcd_pwr_sequencer_chk.sv
module lcd_pwr_sequencer_chk #(
    parameter int STEP_WAIT = 4,
    parameter int LUM_W     = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lcd_pwr_en,
    input logic             bl_pwr_en,
    input logic [LUM_W-1:0] lum_level,
    input logic             busy,
    input logic             done
);

    int busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_len <= 0;
        else
            busy_len <= busy_len + 1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!lcd_pwr_en && !bl_pwr_en && lum_level == '0 && !busy && !done));

    // R3
    bl_needs_lcd_chk: assert property (@(posedge clk) disable iff (rst)
        bl_pwr_en |-> lcd_pwr_en);

    // R4
    lum_needs_bl_chk: assert property (@(posedge clk) disable iff (rst)
        (lum_level != '0) |-> bl_pwr_en);

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7
    rails_move_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({lcd_pwr_en, bl_pwr_en, lum_level}) |-> (busy || done));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_len < 2 * STEP_WAIT));

    // R3
    lum_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (lum_level == '0) || (lum_level == '1));

endmodule

bind lcd_pwr_sequencer lcd_pwr_sequencer_chk #(
    .STEP_WAIT (STEP_WAIT),
    .LUM_W     (LUM_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lcd_pwr_en (lcd_pwr_en),
    .bl_pwr_en  (bl_pwr_en),
    .lum_level  (lum_level),
    .busy       (busy),
    .done       (done)
);

// File: tb/lcd_pwr_sequencer_test.sv
`timescale 1ns/1ps
module lcd_pwr_sequencer_test;

    localparam int D = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       resume_req = 1'b0;
    logic       suspend_req = 1'b0;
    logic       standby_req = 1'b0;
    logic       console_own = 1'b1;
    logic       lcd_pwr_en;
    logic       bl_pwr_en;
    logic [7:0] lum_level;
    logic       busy;
    logic       done;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    string cur_tag = "R1";
    bit    finished = 1'b0;

    // reference model state
    int m_pend = 3;   // 0 none, 1 wake, 2 sleep, 3 boot
    int m_busy = 0;
    int m_t0 = 0;
    int m_up = 0;
    int m_lcd = 0;
    int m_bl = 0;
    int m_lum = 0;
    int m_done = 0;

    always #2.5 clk = ~clk;

    lcd_pwr_sequencer #(.STEP_WAIT(D), .LUM_W(8)) uut (
        .clk         (clk),
        .rst         (rst),
        .resume_req  (resume_req),
        .suspend_req (suspend_req),
        .standby_req (standby_req),
        .console_own (console_own),
        .lcd_pwr_en  (lcd_pwr_en),
        .bl_pwr_en   (bl_pwr_en),
        .lum_level   (lum_level),
        .busy        (busy),
        .done        (done)
    );

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // elapsed-time reference model
    always @(posedge clk) begin
        int new_req;
        int was_busy;
        int e;
        cyc++;
        new_req = (suspend_req || standby_req) ? 2 : (resume_req ? 1 : 0);
        if (rst) begin
            m_pend = 3; m_busy = 0; m_lcd = 0; m_bl = 0; m_lum = 0; m_done = 0;
        end else begin
            was_busy = m_busy;
            m_done = 0;
            if (was_busy != 0) begin
                e = cyc - m_t0;
                if (e == D) begin
                    if (m_up != 0) m_bl = 1; else m_bl = 0;
                end else if (e == 2 * D) begin
                    if (m_up != 0) m_lum = 255; else m_lcd = 0;
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (m_pend != 0) begin
                if (m_pend == 1 && !console_own) begin
                    m_done = 1;
                end else begin
                    m_up = ((m_pend == 1 || m_pend == 3) && console_own) ? 1 : 0;
                    m_busy = 1;
                    m_t0 = cyc;
                    if (m_up != 0) m_lcd = 1; else m_lum = 0;
                end
            end
            if (new_req != 0) m_pend = new_req;
            else if (was_busy == 0) m_pend = 0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cyc > 1) begin
            checks++;
            if (lcd_pwr_en !== m_lcd[0] || bl_pwr_en !== m_bl[0] || lum_level !== m_lum[7:0] ||
                busy !== m_busy[0] || done !== m_done[0]) begin
                failures++;
                $display("FAIL %s model lcd/bl/lum/busy/done actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d (t=%0t)",
                         cur_tag, lcd_pwr_en, bl_pwr_en, lum_level, busy, done,
                         m_lcd, m_bl, m_lum, m_busy, m_done, $time);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_tag = "R1";
        tick(3);
        check_eq("R1", "lcd", int'(lcd_pwr_en), 0);
        check_eq("R1", "bl", int'(bl_pwr_en), 0);
        check_eq("R1", "lum", int'(lum_level), 0);
        check_eq("R1", "busy/done", int'(busy) + int'(done), 0);

        // R2: boot with console owned -> wake order (R3 spacing)
        cur_tag = "R2";
        rst = 1'b0;
        tick(1);
        check_eq("R2", "lcd after boot edge", int'(lcd_pwr_en), 1);
        check_eq("R3", "bl not yet", int'(bl_pwr_en), 0);
        tick(D - 1);
        check_eq("R3", "bl before wait ends", int'(bl_pwr_en), 0);
        tick(1);
        check_eq("R3", "bl after wait", int'(bl_pwr_en), 1);
        tick(D);
        check_eq("R3", "lum max", int'(lum_level), 255);
        check_eq("R7", "done at end", int'(done), 1);
        check_eq("R7", "busy at end", int'(busy), 0);
        tick(1);
        check_eq("R7", "done one cycle", int'(done), 0);
        tick(2);

        // R4 and R10: suspend from fully on
        cur_tag = "R4";
        suspend_req = 1'b1; tick(1); suspend_req = 1'b0;
        check_eq("R10", "lum unchanged at request edge", int'(lum_level), 255);
        tick(1);
        check_eq("R10", "lum drops next edge", int'(lum_level), 0);
        check_eq("R4", "bl still on", int'(bl_pwr_en), 1);
        tick(D);
        check_eq("R4", "bl off", int'(bl_pwr_en), 0);
        check_eq("R4", "lcd still on", int'(lcd_pwr_en), 1);
        tick(D);
        check_eq("R4", "lcd off", int'(lcd_pwr_en), 0);
        tick(3);

        // wake again, then R6: refused wake while on
        cur_tag = "R3";
        resume_req = 1'b1; tick(1); resume_req = 1'b0;
        tick(2 * D + 3);
        cur_tag = "R6";
        console_own = 1'b0;
        resume_req = 1'b1; tick(1); resume_req = 1'b0;
        tick(1);
        check_eq("R6", "done pulse", int'(done), 1);
        check_eq("R6", "busy low", int'(busy), 0);
        check_eq("R6", "lum kept", int'(lum_level), 255);
        tick(2 * D);
        check_eq("R6", "lcd kept", int'(lcd_pwr_en), 1);
        check_eq("R6", "bl kept", int'(bl_pwr_en), 1);
        console_own = 1'b1;

        // R5: standby behaves as suspend
        cur_tag = "R5";
        standby_req = 1'b1; tick(1); standby_req = 1'b0;
        tick(1);
        check_eq("R5", "lum first", int'(lum_level), 0);
        tick(D);
        check_eq("R5", "bl second", int'(bl_pwr_en), 0);
        tick(D);
        check_eq("R5", "lcd third", int'(lcd_pwr_en), 0);
        tick(3);

        // R8: requests during a run; newest wins
        cur_tag = "R8";
        resume_req = 1'b1; tick(1); resume_req = 1'b0;
        tick(2);
        resume_req = 1'b1; tick(1); resume_req = 1'b0;
        tick(1);
        standby_req = 1'b1; tick(1); standby_req = 1'b0;
        tick(2 * D);
        check_eq("R8", "sleep served after wake", int'(lum_level), 0);
        check_eq("R8", "busy on pending run", int'(busy), 1);
        tick(2 * D + 2);
        check_eq("R8", "lcd off at end", int'(lcd_pwr_en), 0);

        // request landing in the done cycle
        resume_req = 1'b1; tick(1); resume_req = 1'b0;
        tick(2 * D);
        suspend_req = 1'b1; tick(1); suspend_req = 1'b0;
        tick(2 * D + 3);
        check_eq("R8", "done-cycle request served", int'(lcd_pwr_en), 0);

        // R9: simultaneous wake and sleep
        cur_tag = "R9";
        resume_req = 1'b1; suspend_req = 1'b1; tick(1);
        resume_req = 1'b0; suspend_req = 1'b0;
        tick(2 * D + 3);
        check_eq("R9", "sleep wins", int'(lcd_pwr_en), 0);

        // R2: boot without console -> sleep order, outputs stay off
        cur_tag = "R2";
        console_own = 1'b0;
        rst = 1'b1; tick(3); rst = 1'b0;
        tick(1);
        check_eq("R2", "busy on boot sleep", int'(busy), 1);
        check_eq("R2", "lcd stays off", int'(lcd_pwr_en), 0);
        tick(2 * D);
        check_eq("R2", "done after boot sleep", int'(done), 1);
        tick(3);

        finish_run();
    end

endmodule